// File: doc/BRIEF.md
# Triangle Frustum Outcode Classifier with Boundary Blend

This block sits ahead of a triangle clipper. It receives one triangle per transfer as three vertices in homogeneous clip space (x, y, z, w). Each coordinate is a signed fixed-point value. Every vertex is tested against the six planes ±w, and the result is packed into a 6-bit region code. The triangle is then given one of three labels: kept as it is, thrown away, or sent on to the clipper. The label depends only on how many of its vertices lie outside.

The same transfer also carries one edge-split job. It consists of an unsigned fractional parameter t and two four-component attribute vectors, C0 and C1. The block returns t·C0 + (1−t)·C1 per component, rounded and clamped to the component width. A clipper can use this to produce the attributes of a vertex that it places on a boundary. The parameter t is computed upstream.

Both operations share a two-stage pipeline with valid/ready flow control on each side. A result leaves the block two clock edges after its input is accepted. Back-pressure stalls the whole pipe, and the output is held while it stalls.

Top module: `clip_outcode_unit`

## Requirements
- R1: Each vertex code is 6 bits, from bit 5 down to bit 0: {z>w, z<−w, y>w, y<−w, x>w, x<−w}. A bit is 1 when that comparison holds, which means the vertex is outside that plane. The code of vertex v is at code_o[6v+5:6v], and its coordinates are at bits [CW·v +: CW] of vx_i, vy_i, vz_i and vw_i.
- R2: All comparisons are strict and use full precision, including −w for the most negative w. A coordinate exactly equal to w or to −w gives a 0 bit.
- R3: When all three codes are zero, class_o is 2'b00 (accept).
- R4: When all three codes are nonzero, class_o is 2'b10 (cull).
- R5: When one or two codes are nonzero, class_o is 2'b01 (clip). The value 2'b11 never appears on a valid output.
- R6: blend_t_i is unsigned Q1.15, so 0x8000 is 1.0 and values up to 0xFFFF are legal. Component c of blend_o is floor((t·C0 + (32768−t)·C1 + 16384) / 32768). This rounds to nearest, with ties going toward +infinity. Component c of each vector is at bits [AW·c +: AW].
- R7: A blend result outside the signed AW-bit range is clamped to the largest or smallest representable value.
- R8: A transfer accepted at clock edge k appears with out_valid high after edge k+1, provided the output was free at that edge. With out_ready held high, in_ready stays high and one triangle is accepted every cycle.
- R9: While out_valid is high and out_ready is low, in_ready is low and code_o, class_o and blend_o hold their values.
- R10: While rst_n is low and after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Block can take an input this cycle |
| vx_i | input | 3·CW | Signed x of vertices 0..2 |
| vy_i | input | 3·CW | Signed y of vertices 0..2 |
| vz_i | input | 3·CW | Signed z of vertices 0..2 |
| vw_i | input | 3·CW | Signed w of vertices 0..2 |
| blend_t_i | input | TW | Blend parameter t, unsigned Q1.15 |
| blend_c0_i | input | NC·AW | Signed endpoint C0 components |
| blend_c1_i | input | NC·AW | Signed endpoint C1 components |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| code_o | output | 18 | Region codes of vertices 0..2 |
| class_o | output | 2 | 00 accept, 01 clip, 10 cull |
| blend_o | output | NC·AW | Blended components |

## Verification
Wrong stage-one state shows up as a wrong code or an unrounded blend two edges after the triangle is accepted. The class field then disagrees with the code field on that same output beat. A wrong valid or stall state shows up within one cycle in one of three ways: a result that is lost, a result that is duplicated, or output data that changes while out_ready is low. The random mix of back-pressure and directed boundary values is meant to reach each of these within a few hundred transfers. The directed values cover coordinates exactly at ±w, negative w, ties at half a unit, and extrapolating t.

// File: rtl/clip_pkg.sv
package clip_pkg;
    localparam int CODE_W = 6;
    localparam int NUM_VTX = 3;

    typedef enum logic [1:0] {
        CLS_ACCEPT = 2'b00,
        CLS_CLIP   = 2'b01,
        CLS_CULL   = 2'b10
    } tri_class_e;
endpackage

// File: rtl/clip_outcode_calc.sv
module clip_outcode_calc
    import clip_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic signed [CW-1:0]     x_i,
    input  logic signed [CW-1:0]     y_i,
    input  logic signed [CW-1:0]     z_i,
    input  logic signed [CW-1:0]     w_i,
    output logic        [CODE_W-1:0] code_o
);
    // one extra bit so that -w of the most negative w is representable
    logic signed [CW:0] xe, ye, ze, we, nwe;

    always_comb begin
        xe  = (CW+1)'(x_i);
        ye  = (CW+1)'(y_i);
        ze  = (CW+1)'(z_i);
        we  = (CW+1)'(w_i);
        nwe = -we;
        code_o[5] = (ze > we);
        code_o[4] = (ze < nwe);
        code_o[3] = (ye > we);
        code_o[2] = (ye < nwe);
        code_o[1] = (xe > we);
        code_o[0] = (xe < nwe);
    end
endmodule

// File: rtl/clip_lerp_mul.sv
module clip_lerp_mul #(
    parameter int AW = 16,
    parameter int TW = 16,
    localparam int SW = AW + TW + 2
) (
    input  logic        [TW-1:0] t_i,
    input  logic signed [AW-1:0] c0_i,
    input  logic signed [AW-1:0] c1_i,
    output logic signed [SW-1:0] sum_o
);
    localparam logic signed [SW-1:0] ONE_Q = SW'(1) << (TW - 1);

    logic signed [SW-1:0] t_w, u_w, a_w, b_w;

    always_comb begin
        t_w   = SW'($signed({1'b0, t_i}));
        u_w   = ONE_Q - t_w;
        a_w   = SW'(c0_i);
        b_w   = SW'(c1_i);
        sum_o = (t_w * a_w) + (u_w * b_w);
    end
endmodule

// File: rtl/clip_lerp_rnd.sv
module clip_lerp_rnd #(
    parameter int AW = 16,
    parameter int TW = 16,
    localparam int SW = AW + TW + 2
) (
    input  logic signed [SW-1:0] sum_i,
    output logic signed [AW-1:0] res_o
);
    localparam logic signed [SW-1:0] HALF_Q = SW'(1) << (TW - 2);
    localparam logic signed [SW-1:0] MAX_V  = (SW'(1) << (AW - 1)) - SW'(1);
    localparam logic signed [SW-1:0] MIN_V  = -(SW'(1) << (AW - 1));

    logic signed [SW-1:0] shifted;

    always_comb begin
        shifted = (sum_i + HALF_Q) >>> (TW - 1);
        if (shifted > MAX_V) begin
            res_o = AW'(MAX_V);
        end else if (shifted < MIN_V) begin
            res_o = AW'(MIN_V);
        end else begin
            res_o = AW'(shifted);
        end
    end
endmodule

// File: rtl/clip_outcode_unit.sv
module clip_outcode_unit
    import clip_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 16,
    parameter int TW = 16,
    parameter int NC = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [NUM_VTX*CW-1:0]        vx_i,
    input  logic [NUM_VTX*CW-1:0]        vy_i,
    input  logic [NUM_VTX*CW-1:0]        vz_i,
    input  logic [NUM_VTX*CW-1:0]        vw_i,
    input  logic [TW-1:0]                blend_t_i,
    input  logic [NC*AW-1:0]             blend_c0_i,
    input  logic [NC*AW-1:0]             blend_c1_i,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [NUM_VTX*CODE_W-1:0]    code_o,
    output logic [1:0]                   class_o,
    output logic [NC*AW-1:0]             blend_o
);
    localparam int SW    = AW + TW + 2;
    localparam int CNT_W = $clog2(NUM_VTX + 1);

    typedef struct packed {
        logic                              s1_vld;
        logic [NUM_VTX-1:0][CODE_W-1:0]    s1_code;
        logic [NC-1:0][SW-1:0]             s1_sum;
        logic                              s2_vld;
        logic [NUM_VTX-1:0][CODE_W-1:0]    s2_code;
        tri_class_e                        s2_cls;
        logic [NC-1:0][AW-1:0]             s2_blend;
    } pipe_t;

    pipe_t st_d, st_q;

    logic                           adv;
    logic [NUM_VTX-1:0][CODE_W-1:0] code_w;
    logic [NC-1:0][SW-1:0]          sum_w;
    logic [NC-1:0][AW-1:0]          rnd_w;
    logic [CNT_W-1:0]               n_out;
    tri_class_e                     cls_w;

    // stage one: per-vertex outcodes
    for (genvar v = 0; v < NUM_VTX; v++) begin : g_vtx
        clip_outcode_calc #(.CW(CW)) u_oc (
            .x_i    ($signed(vx_i[v*CW +: CW])),
            .y_i    ($signed(vy_i[v*CW +: CW])),
            .z_i    ($signed(vz_i[v*CW +: CW])),
            .w_i    ($signed(vw_i[v*CW +: CW])),
            .code_o (code_w[v])
        );
    end

    // stage one products, stage two rounding per component
    for (genvar c = 0; c < NC; c++) begin : g_cmp
        logic signed [SW-1:0] sum_c;
        logic signed [AW-1:0] rnd_c;

        clip_lerp_mul #(.AW(AW), .TW(TW)) u_mul (
            .t_i   (blend_t_i),
            .c0_i  ($signed(blend_c0_i[c*AW +: AW])),
            .c1_i  ($signed(blend_c1_i[c*AW +: AW])),
            .sum_o (sum_c)
        );

        clip_lerp_rnd #(.AW(AW), .TW(TW)) u_rnd (
            .sum_i ($signed(st_q.s1_sum[c])),
            .res_o (rnd_c)
        );

        assign sum_w[c] = sum_c;
        assign rnd_w[c] = rnd_c;
    end

    // stage two: count vertices outside and classify
    always_comb begin
        n_out = '0;
        for (int v = 0; v < NUM_VTX; v++) begin
            if (st_q.s1_code[v] != '0) begin
                n_out = n_out + CNT_W'(1);
            end
        end
        if (n_out == '0) begin
            cls_w = CLS_ACCEPT;
        end else if (n_out == CNT_W'(NUM_VTX)) begin
            cls_w = CLS_CULL;
        end else begin
            cls_w = CLS_CLIP;
        end
    end

    always_comb begin
        adv  = !st_q.s2_vld || out_ready;
        st_d = st_q;
        if (adv) begin
            st_d.s1_vld = in_valid;
            if (in_valid) begin
                st_d.s1_code = code_w;
                st_d.s1_sum  = sum_w;
            end
            st_d.s2_vld = st_q.s1_vld;
            if (st_q.s1_vld) begin
                st_d.s2_code  = st_q.s1_code;
                st_d.s2_cls   = cls_w;
                st_d.s2_blend = rnd_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = adv;
    assign out_valid = st_q.s2_vld;
    assign code_o    = st_q.s2_code;
    assign class_o   = st_q.s2_cls;
    assign blend_o   = st_q.s2_blend;
endmodule

// File: rtl/clip_outcode_chk.sv
module clip_outcode_chk
    import clip_pkg::*;
#(
    parameter int AW = 16,
    parameter int NC = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [NUM_VTX*CODE_W-1:0] code_o,
    input logic [1:0]                class_o,
    input logic [NC*AW-1:0]          blend_o
);
    logic v0_out, v1_out, v2_out;
    assign v0_out = |code_o[0*CODE_W +: CODE_W];
    assign v1_out = |code_o[1*CODE_W +: CODE_W];
    assign v2_out = |code_o[2*CODE_W +: CODE_W];

    // R9: stalled output holds its data
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(code_o) && $stable(class_o) && $stable(blend_o));

    // R3: accept only with all codes zero
    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && class_o == CLS_ACCEPT |-> !v0_out && !v1_out && !v2_out);

    // R4: cull only with every vertex outside
    assert_cull_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && class_o == CLS_CULL |-> v0_out && v1_out && v2_out);

    // R5: clip only with a mix of inside and outside vertices
    assert_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && class_o == CLS_CLIP |-> (v0_out || v1_out || v2_out) && !(v0_out && v1_out && v2_out));

    // R5: no unused class encoding
    assert_legal_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> class_o != 2'b11);

    // R8: an accepted transfer reaches the output after the next free edge
    assert_flow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready ##1 (!out_valid || out_ready) |=> out_valid);
endmodule

bind clip_outcode_unit clip_outcode_chk #(.AW(AW), .NC(NC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .code_o    (code_o),
    .class_o   (class_o),
    .blend_o   (blend_o)
);

// File: tb/clip_outcode_unit_bench.sv
module clip_outcode_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int AW = 16;
    localparam int TW = 16;
    localparam int NC = 4;
    localparam int NV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [NV*CW-1:0] vx_i = '0, vy_i = '0, vz_i = '0, vw_i = '0;
    logic [TW-1:0]    blend_t_i = '0;
    logic [NC*AW-1:0] blend_c0_i = '0, blend_c1_i = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [NV*6-1:0]  code_o;
    logic [1:0]       class_o;
    logic [NC*AW-1:0] blend_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    clip_outcode_unit #(.CW(CW), .AW(AW), .TW(TW), .NC(NC)) u_clip_outcode_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .vx_i(vx_i), .vy_i(vy_i), .vz_i(vz_i), .vw_i(vw_i),
        .blend_t_i(blend_t_i), .blend_c0_i(blend_c0_i), .blend_c1_i(blend_c1_i),
        .out_valid(out_valid), .out_ready(out_ready),
        .code_o(code_o), .class_o(class_o), .blend_o(blend_o)
    );

    typedef struct {
        logic [NV*6-1:0]  code;
        logic [1:0]       cls;
        logic [NC*AW-1:0] blend;
    } exp_t;

    exp_t expq[$];
    int n_chk = 0;
    int n_fail = 0;

    int st_x[NV], st_y[NV], st_z[NV], st_w[NV];
    int st_t;
    int st_c0[NC], st_c1[NC];

    logic             stalled = 1'b0;
    logic [NV*6-1:0]  hold_code;
    logic [1:0]       hold_cls;
    logic [NC*AW-1:0] hold_blend;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_code(input int x, input int y, input int z, input int w);
        return {z > w, z < -w, y > w, y < -w, x > w, x < -w};
    endfunction

    function automatic logic [1:0] ref_cls(input logic [NV*6-1:0] c);
        int n = 0;
        for (int v = 0; v < NV; v++) if (c[v*6 +: 6] != 6'd0) n++;
        if (n == 0) return 2'b00;
        if (n == NV) return 2'b10;
        return 2'b01;
    endfunction

    function automatic logic [AW-1:0] ref_blend(input int t, input int c0, input int c1);
        longint s = longint'(t) * c0 + longint'(32768 - t) * c1 + 16384;
        longint r = s >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return AW'(r);
    endfunction

    task automatic set_v(input int v, input int x, input int y, input int z, input int w);
        st_x[v] = x; st_y[v] = y; st_z[v] = z; st_w[v] = w;
    endtask

    task automatic set_c(input int c, input int c0, input int c1);
        st_c0[c] = c0; st_c1[c] = c1;
    endtask

    function automatic string cls_req(input logic [1:0] c);
        if (c == 2'b00) return "R3";
        if (c == 2'b10) return "R4";
        return "R5";
    endfunction

    // one clock: drive at negedge, then observe before the next posedge
    task automatic step(input bit iv, input bit ordy);
        exp_t e, g;
        @(negedge clk);
        in_valid  = iv;
        out_ready = ordy;
        for (int v = 0; v < NV; v++) begin
            vx_i[v*CW +: CW] = CW'(st_x[v]);
            vy_i[v*CW +: CW] = CW'(st_y[v]);
            vz_i[v*CW +: CW] = CW'(st_z[v]);
            vw_i[v*CW +: CW] = CW'(st_w[v]);
        end
        blend_t_i = TW'(st_t);
        for (int c = 0; c < NC; c++) begin
            blend_c0_i[c*AW +: AW] = AW'(st_c0[c]);
            blend_c1_i[c*AW +: AW] = AW'(st_c1[c]);
        end
        #1;
        if (stalled) begin
            chk(out_valid === 1'b1, "R9 valid held", 64'(out_valid), 64'd1);
            chk(code_o === hold_code && class_o === hold_cls && blend_o === hold_blend,
                "R9 data held", 64'(blend_o), 64'(hold_blend));
        end
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8 unexpected output", 64'(code_o), 64'd0);
            end else begin
                g = expq.pop_front();
                chk(code_o === g.code, "R1 codes", 64'(code_o), 64'(g.code));
                chk(class_o === g.cls, cls_req(g.cls), 64'(class_o), 64'(g.cls));
                chk(blend_o === g.blend, "R6/R7 blend", 64'(blend_o), 64'(g.blend));
            end
        end
        if (out_valid && !out_ready) begin
            chk(in_ready === 1'b0, "R9 in_ready low", 64'(in_ready), 64'd0);
            stalled    = 1'b1;
            hold_code  = code_o;
            hold_cls   = class_o;
            hold_blend = blend_o;
        end else begin
            stalled = 1'b0;
        end
        if (in_valid && in_ready) begin
            for (int v = 0; v < NV; v++)
                e.code[v*6 +: 6] = ref_code(st_x[v], st_y[v], st_z[v], st_w[v]);
            e.cls = ref_cls(e.code);
            for (int c = 0; c < NC; c++)
                e.blend[c*AW +: AW] = ref_blend(st_t, st_c0[c], st_c1[c]);
            expq.push_back(e);
        end
    endtask

    function automatic int pick_coord(input int w);
        case ($urandom_range(0, 5))
            0: return w;
            1: return -w;
            2: return w + 1;
            3: return -w - 1;
            default: return $urandom_range(0, 400) - 200;
        endcase
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd0);
        summary();
        $finish;
    end

    initial begin
        int w;
        void'($urandom(32'd4711));
        for (int v = 0; v < NV; v++) set_v(v, 0, 0, 0, 100);
        st_t = 0;
        for (int c = 0; c < NC; c++) set_c(c, 0, 0);

        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid === 1'b0, "R10 out_valid in reset", 64'(out_valid), 64'd0);
        chk(in_ready === 1'b1, "R10 in_ready in reset", 64'(in_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid === 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);

        // R8 latency, R3 accept, t=0 gives C1
        set_c(0, 1000, -7); set_c(1, -32768, 32767); set_c(2, 5, 0); set_c(3, 0, -1);
        step(1, 1);
        step(0, 1);
        chk(out_valid === 1'b0, "R8 not yet valid", 64'(out_valid), 64'd0);
        step(0, 1);
        chk(out_valid === 1'b1, "R8 valid after second edge", 64'(out_valid), 64'd1);

        // R1 far plane only: code 100000, clip (R5); t=1.0 gives C0 (R6)
        set_v(0, 0, 0, 200, 100);
        st_t = 16'h8000;
        set_c(0, 1234, 55); set_c(1, -900, 3); set_c(2, 32767, -32768); set_c(3, -1, 1);
        step(1, 1);

        // R1 individual bits, all outside: cull (R4); ties (R6)
        set_v(0, -200, 0, 0, 100);
        set_v(1, 200, 0, 0, 100);
        set_v(2, 0, -200, 0, 100);
        st_t = 16'h4000;
        set_c(0, 1, 0); set_c(1, -1, 0); set_c(2, 3, 4); set_c(3, -3, -4);
        step(1, 1);

        // R1 remaining bits, two outside: clip (R5); saturation (R7)
        set_v(0, 0, 200, 0, 100);
        set_v(1, 0, 0, -200, 100);
        set_v(2, 0, 0, 0, 100);
        st_t = 16'hFFFF;
        set_c(0, 32767, -32768); set_c(1, -32768, 32767); set_c(2, 100, 100); set_c(3, 0, 0);
        step(1, 1);

        // R2 exact boundaries, including most negative w
        set_v(0, 100, -100, 100, 100);
        set_v(1, 32767, -32768, 0, -32768);
        set_v(2, 0, 0, 0, 0);
        step(1, 1);

        // R1 negative w sets both bits of an axis
        set_v(0, 0, 0, 0, -5);
        set_v(1, 0, 0, 0, 100);
        set_v(2, 0, 0, 0, 100);
        step(1, 1);
        repeat (3) step(0, 1);

        // random mix with back-pressure
        for (int i = 0; i < 600; i++) begin
            for (int v = 0; v < NV; v++) begin
                w = $urandom_range(0, 250) - 50;
                set_v(v, pick_coord(w), pick_coord(w), pick_coord(w), w);
            end
            st_t = $urandom_range(0, 65535);
            for (int c = 0; c < NC; c++)
                set_c(c, $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768);
            step($urandom_range(0, 9) < 8, $urandom_range(0, 3) != 0);
        end
        repeat (4) step(0, 1);

        // R8 full throughput with output always ready
        for (int i = 0; i < 8; i++) begin
            set_v(0, i, 0, 0, 3);
            st_t = i * 4096;
            step(1, 1);
            chk(in_ready === 1'b1, "R8 back-to-back accept", 64'(in_ready), 64'd1);
        end
        repeat (4) step(0, 1);
        chk(expq.size() == 0, "R8 all results delivered", 64'(expq.size()), 64'd0);

        summary();
        $finish;
    end
endmodule